// File: doc/BRIEF.md
# Nested Priority Vectored Interrupt Controller

This block gathers thirty-two interrupt request lines and turns them into two active-low processor request outputs: a fast request and a normal request. Line 0 is the dedicated fast-interrupt input. Line 1 belongs to system peripherals, and lines 2 to 31 belong to embedded peripherals or external pins. Every line has an enable bit, a three-bit priority, a trigger mode and a 32-bit vector word. A fast-forcing bit can move any line onto the fast request.

Software sets the block up through a simple word-addressed register port. To take a normal interrupt, software reads the vector register. That read returns the vector word of the winning line and marks the interrupt as accepted. On acceptance the block pushes the winner's priority onto an eight-entry hardware stack and clears that line's edge latch. The normal request then stays quiet until some line of strictly higher priority becomes pending, so handlers can nest. Writing the end-of-interrupt register pops the stack.

Two control bits change this flow. A global mask holds both outputs inactive while pending status keeps recording events. A protect bit makes vector reads free of side effects; in that mode a write to the vector register performs the acceptance.

Top module: `pirq_ctrl`

Register map (word addresses on `bus_addr`): 0x00 vector (read returns the vector and accepts; in protect mode a write accepts), 0x01 end of interrupt (write pops), 0x02 enable bits (1 = enabled), 0x03 fast-forcing bits, 0x04 control (bit 0 global mask, bit 1 protect), 0x05 pending bits (read only), 0x06 spurious vector, 0x07 edge-latch clear (write 1 per bit), 0x40+n vector word of line n, 0x80+n configuration of line n (bits [2:0] priority, bits [5:4] trigger mode).

## Requirements
- R1: After reset both request outputs are high, the pending word reads 0, and a vector read returns the spurious value, which resets to 0.
- R2: Line 0, when pending and enabled, drives the fast request output low and never drives the normal request.
- R3: The normal request goes to the enabled pending line, among lines 1 to 31 that are not forced, with the highest priority (7 is highest). On a tie the lowest line number wins. A vector read returns the winner's vector word.
- R4: An unprotected vector read accepts the winner and pushes its priority. After that the normal request stays high unless a line of strictly higher priority than the stack top is pending, in which case it goes low again.
- R5: A write to the end-of-interrupt register pops one stack level, so lines above the restored level, or any line once the stack is empty, can request again.
- R6: Trigger mode encoding: 00 high level, 01 rising edge, 10 low level, 11 falling edge. On internal lines 0 to 15, bit 5 of the configuration word is dropped on write and reads back 0.
- R7: Acceptance clears the accepted line's edge latch. An edge-triggered line stays pending after its input returns to idle, until it is cleared.
- R8: A set fast-forcing bit sends that line to the fast request and removes it from the normal request.
- R9: While the global mask is set both outputs stay high, and the pending word still shows events.
- R10: With protect set, vector reads neither accept, push nor clear latches. A write to the vector register accepts instead.
- R11: If no line qualifies when the vector register is read, the spurious value is returned and the stack is left unchanged.
- R12: A disabled line makes no request but still shows in the pending word.
- R13: Writing 1 to a bit of the edge-latch clear register clears that line's edge latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Raw interrupt request lines |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| nfiq_n | output | 1 | Fast request to the processor, active low |
| nirq_n | output | 1 | Normal request to the processor, active low |

## Verification
The embedded assertions check several rules on every cycle. The stack never overflows and never sees a push and a pop together. A read with no qualifying line or a protected read leaves the stack depth untouched. The global mask silences both outputs on the next cycle. The arbiter winner is always a real candidate, and a latched edge holds until something clears it. The tie order between equal priorities, the nesting sequence across pushes and pops, each of the four trigger modes, the internal-line polarity drop, fast forcing and the exact vector values returned can only be shown by the bench's directed and random scenarios.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int PRIO_W = 3;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        TRIG_LVL_HI  = 2'b00,
        TRIG_RISE    = 2'b01,
        TRIG_LVL_LO  = 2'b10,
        TRIG_FALL    = 2'b11
    } trig_e;

    typedef struct packed {
        trig_e               trig;
        logic [PRIO_W-1:0]   prio;
    } src_cfg_t;

    localparam logic [ADDR_W-1:0] A_VEC    = 8'h00;
    localparam logic [ADDR_W-1:0] A_EOI    = 8'h01;
    localparam logic [ADDR_W-1:0] A_ENABLE = 8'h02;
    localparam logic [ADDR_W-1:0] A_FORCE  = 8'h03;
    localparam logic [ADDR_W-1:0] A_CTRL   = 8'h04;
    localparam logic [ADDR_W-1:0] A_PEND   = 8'h05;
    localparam logic [ADDR_W-1:0] A_SPUR   = 8'h06;
    localparam logic [ADDR_W-1:0] A_CLR    = 8'h07;
    localparam logic [1:0] RGN_VEC = 2'b01;
    localparam logic [1:0] RGN_CFG = 2'b10;

    function automatic logic [DATA_W-1:0] pack_cfg(input src_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[PRIO_W-1:0] = c.prio;
        w[5:4] = c.trig;
        return w;
    endfunction

endpackage

// File: rtl/pirq_src_cond.sv
module pirq_src_cond
    import pirq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  irq_raw,
    input  trig_e trig,
    input  logic  clr,
    output logic  pending
);
    logic sync_q, prev_q, edge_q, hit;

    always_comb begin
        if (trig[1]) hit = prev_q & ~sync_q;
        else         hit = sync_q & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b0;
            prev_q <= 1'b0;
            edge_q <= 1'b0;
        end else begin
            sync_q <= irq_raw;
            prev_q <= sync_q;
            if (hit)      edge_q <= 1'b1;
            else if (clr) edge_q <= 1'b0;
        end
    end

    assign pending = trig[0] ? edge_q : (sync_q ^ trig[1]);

    p_edge_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (edge_q && !clr) |=> edge_q);

endmodule

// File: rtl/pirq_arbiter.sv
module pirq_arbiter
    import pirq_pkg::*;
#(
    parameter int NSRC  = 32,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NSRC-1:0]               cand,
    input  logic [NSRC-1:0][PRIO_W-1:0]   prio,
    output logic                          win_valid,
    output logic [IDX_W-1:0]              win_idx,
    output logic [PRIO_W-1:0]             win_prio
);
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (cand[i] && (!win_valid || prio[i] >= win_prio)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_prio  = prio[i];
            end
        end
    end

    p_winner_real_r3: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> (cand[win_idx] && prio[win_idx] == win_prio));

endmodule

// File: rtl/pirq_prio_stack.sv
module pirq_prio_stack
    import pirq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              pop,
    output logic              busy,
    output logic [PRIO_W-1:0] top_prio,
    output logic [CNT_W-1:0]  depth
);
    logic [PRIO_W-1:0] stk_q [DEPTH];
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
        end else if (push && cnt_q != CNT_W'(DEPTH)) begin
            stk_q[cnt_q[PTR_W-1:0]] <= push_prio;
            cnt_q <= cnt_q + 1'b1;
        end else if (pop && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    logic [CNT_W-1:0] top_ptr;
    assign top_ptr  = cnt_q - 1'b1;
    assign busy     = (cnt_q != '0);
    assign top_prio = busy ? stk_q[top_ptr[PTR_W-1:0]] : '0;
    assign depth    = cnt_q;

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt_q < CNT_W'(DEPTH)));
    p_no_collide_r5: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));
    p_push_grows_r4: assert property (@(posedge clk) disable iff (rst)
        push |=> (cnt_q == $past(cnt_q) + 1'b1));
    p_pop_shrinks_r5: assert property (@(posedge clk) disable iff (rst)
        (pop && busy) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
    import pirq_pkg::*;
#(
    parameter int          NSRC        = 32,
    parameter int          STACK_DEPTH = 8,
    parameter logic [31:0] EXT_MASK    = 32'hFFFF_0000,
    localparam int IDX_W = $clog2(NSRC),
    localparam int CNT_W = $clog2(STACK_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   irq_in,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              nfiq_n,
    output logic              nirq_n
);
    src_cfg_t          cfg_q [NSRC];
    logic [DATA_W-1:0] vec_q [NSRC];
    logic [NSRC-1:0]   en_q, force_q;
    logic              gmask_q, protect_q;
    logic [DATA_W-1:0] spur_q;
    logic              nfiq_q, nirq_q;

    logic [NSRC-1:0]              pend, clr, cand;
    logic [NSRC-1:0][PRIO_W-1:0]  prio_vec;
    logic                         win_valid, stk_busy, qualify, ack, push, eoi;
    logic [IDX_W-1:0]             win_idx;
    logic [PRIO_W-1:0]            win_prio, top_prio;
    logic [CNT_W-1:0]             stk_depth;
    logic                         fast_any;

    // address decode
    logic in_vec_rgn, in_cfg_rgn;
    logic [IDX_W-1:0] rgn_idx;
    assign rgn_idx    = bus_addr[IDX_W-1:0];
    assign in_vec_rgn = (bus_addr[7:6] == RGN_VEC) && (int'(bus_addr[5:0]) < NSRC);
    assign in_cfg_rgn = (bus_addr[7:6] == RGN_CFG) && (int'(bus_addr[5:0]) < NSRC);

    assign ack  = (bus_rd && !protect_q && bus_addr == A_VEC) ||
                  (bus_wr &&  protect_q && bus_addr == A_VEC);
    assign eoi  = bus_wr && bus_addr == A_EOI;
    assign qualify = win_valid && (!stk_busy || win_prio > top_prio);
    assign push = ack && qualify;

    // per-line conditioning
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign clr[g] = (push && win_idx == IDX_W'(g)) ||
                        (bus_wr && bus_addr == A_CLR && bus_wdata[g]);
        assign prio_vec[g] = cfg_q[g].prio;
        if (g == 0) begin : g_fast_line
            assign cand[g] = 1'b0;
        end else begin : g_norm_line
            assign cand[g] = pend[g] & en_q[g] & ~force_q[g];
        end
        pirq_src_cond u_cond (
            .clk     (clk),
            .rst     (rst),
            .irq_raw (irq_in[g]),
            .trig    (cfg_q[g].trig),
            .clr     (clr[g]),
            .pending (pend[g])
        );
    end

    logic [NSRC-1:0] fast_sel;
    assign fast_sel = force_q | NSRC'(1);
    assign fast_any = |(pend & en_q & fast_sel);

    pirq_arbiter #(.NSRC(NSRC)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .cand      (cand),
        .prio      (prio_vec),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_prio  (win_prio)
    );

    pirq_prio_stack #(.DEPTH(STACK_DEPTH)) u_stk (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_prio (win_prio),
        .pop       (eoi),
        .busy      (stk_busy),
        .top_prio  (top_prio),
        .depth     (stk_depth)
    );

    // register file
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSRC; i++) begin
                cfg_q[i] <= '{trig: TRIG_LVL_HI, prio: '0};
                vec_q[i] <= '0;
            end
            en_q      <= '0;
            force_q   <= '0;
            gmask_q   <= 1'b0;
            protect_q <= 1'b0;
            spur_q    <= '0;
        end else if (bus_wr) begin
            if (in_vec_rgn) vec_q[rgn_idx] <= bus_wdata;
            if (in_cfg_rgn) begin
                cfg_q[rgn_idx].prio <= bus_wdata[PRIO_W-1:0];
                cfg_q[rgn_idx].trig <= trig_e'({bus_wdata[5] & EXT_MASK[rgn_idx], bus_wdata[4]});
            end
            case (bus_addr)
                A_ENABLE: en_q    <= bus_wdata[NSRC-1:0];
                A_FORCE:  force_q <= bus_wdata[NSRC-1:0];
                A_CTRL: begin
                    gmask_q   <= bus_wdata[0];
                    protect_q <= bus_wdata[1];
                end
                A_SPUR:   spur_q  <= bus_wdata;
                default: ;
            endcase
        end
    end

    // request outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            nfiq_q <= 1'b1;
            nirq_q <= 1'b1;
        end else begin
            nfiq_q <= ~(fast_any && !gmask_q);
            nirq_q <= ~(qualify && !gmask_q);
        end
    end
    assign nfiq_n = nfiq_q;
    assign nirq_n = nirq_q;

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (in_vec_rgn)      bus_rdata = vec_q[rgn_idx];
        else if (in_cfg_rgn) bus_rdata = pack_cfg(cfg_q[rgn_idx]);
        else begin
            case (bus_addr)
                A_VEC:    bus_rdata = qualify ? vec_q[win_idx] : spur_q;
                A_ENABLE: bus_rdata = DATA_W'(en_q);
                A_FORCE:  bus_rdata = DATA_W'(force_q);
                A_CTRL:   bus_rdata = DATA_W'({protect_q, gmask_q});
                A_PEND:   bus_rdata = DATA_W'(pend);
                A_SPUR:   bus_rdata = spur_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    p_gmask_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        gmask_q |=> (nirq_n && nfiq_n));
    p_spurious_keep_r11: assert property (@(posedge clk) disable iff (rst)
        (ack && !win_valid) |=> $stable(stk_depth));
    p_protect_read_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && protect_q && !eoi) |=> $stable(stk_depth));

endmodule

// File: tb/pirq_ctrl_test.sv
module pirq_ctrl_test;
    import pirq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_in = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        nfiq_n, nirq_n;

    int errors = 0;
    int checks = 0;
    logic [2:0] prio_b [32];

    localparam logic [31:0] SPUR = 32'h5A5A_0000;

    pirq_ctrl uut (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .nfiq_n(nfiq_n), .nirq_n(nirq_n)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] vec_of(input int n);
        return 32'h8000_000C | (32'(n) << 8);
    endfunction

    function automatic int pick(input logic [31:0] act);
        int best = -1;
        for (int i = 1; i < 32; i++)
            if (act[i] && (best < 0 || prio_b[i] > prio_b[best])) best = i;
        return best;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic set_cfg(input int n, input logic [1:0] trig, input logic [2:0] p);
        prio_b[n] = p;
        wr(8'h80 + 8'(n), {26'b0, trig, 1'b0, p});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));
        for (int i = 0; i < 32; i++) prio_b[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;

        // R1 reset state
        chk("R1 nirq", 32'(nirq_n), 1);
        chk("R1 nfiq", 32'(nfiq_n), 1);
        rd(A_PEND, d); chk("R1 pend", d, 0);
        rd(A_VEC, d);  chk("R1 spurious", d, 0);

        for (int i = 0; i < 32; i++) wr(8'h40 + 8'(i), vec_of(i));
        wr(A_SPUR, SPUR);
        wr(A_ENABLE, 32'hFFFF_FFFF);

        // R3 random arbitration, protected reads
        wr(A_CTRL, 32'h2);
        for (int it = 0; it < 20; it++) begin
            logic [31:0] act;
            int w;
            for (int n = 1; n < 16; n++) set_cfg(n, 2'b00, 3'($urandom_range(0, 7)));
            act = $urandom & 32'h0000_FFFE;
            irq_in = act;
            settle();
            w = pick(act);
            chk("R3 nirq random", 32'(nirq_n), (w < 0) ? 1 : 0);
            rd(A_VEC, d);
            chk("R3 vector random", d, (w < 0) ? SPUR : vec_of(w));
        end
        irq_in = '0;
        wr(A_CTRL, 32'h0);
        for (int n = 1; n < 16; n++) set_cfg(n, 2'b00, 3'd0);
        settle();

        // R3 tie between equal priorities
        set_cfg(3, 2'b00, 3'd2); set_cfg(5, 2'b00, 3'd2);
        set_cfg(7, 2'b00, 3'd5); set_cfg(9, 2'b00, 3'd2);
        wr(A_CTRL, 32'h2);
        irq_in = 32'h28; settle();
        rd(A_VEC, d); chk("R3 tie lowest", d, vec_of(3));
        irq_in = 32'hA8; settle();
        rd(A_VEC, d); chk("R3 higher wins", d, vec_of(7));
        irq_in = '0;
        wr(A_CTRL, 32'h0);
        settle();

        // R4 / R5 / R11 nesting
        irq_in = 32'h8; settle();
        rd(A_VEC, d); chk("R4 accept vec", d, vec_of(3));
        settle(); chk("R4 quiet after accept", 32'(nirq_n), 1);
        rd(A_VEC, d); chk("R11 spurious at level", d, SPUR);
        irq_in = 32'h208; settle();
        chk("R4 equal prio no nest", 32'(nirq_n), 1);
        irq_in = 32'h288; settle();
        chk("R4 higher nests", 32'(nirq_n), 0);
        rd(A_VEC, d); chk("R4 nested vec", d, vec_of(7));
        settle(); chk("R4 quiet at level 5", 32'(nirq_n), 1);
        wr(A_EOI, 0); settle();
        chk("R5 pop reexposes higher", 32'(nirq_n), 0);
        irq_in = 32'h208; settle();
        chk("R5 level 2 holds", 32'(nirq_n), 1);
        wr(A_EOI, 0); settle();
        chk("R11 R5 stack empty", 32'(nirq_n), 0);
        irq_in = '0; settle();

        // R6 / R7 falling edge on external line 20
        set_cfg(20, 2'b11, 3'd1);
        irq_in[20] = 1'b1; settle();
        chk("R6 no hit on rise", 32'(nirq_n), 1);
        irq_in[20] = 1'b0; settle();
        chk("R6 fall hit", 32'(nirq_n), 0);
        rd(A_PEND, d); chk("R7 latched", d[20], 1);
        rd(A_VEC, d); chk("R7 vec 20", d, vec_of(20));
        settle(); chk("R7 nirq after clear", 32'(nirq_n), 1);
        rd(A_PEND, d); chk("R7 edge cleared", d[20], 0);
        wr(A_EOI, 0);

        // R6 internal polarity dropped
        set_cfg(4, 2'b10, 3'd0);
        rd(8'h84, d); chk("R6 internal mode", 32'(d[5:4]), 0);
        settle(); chk("R6 internal no low level", 32'(nirq_n), 1);

        // R6 / R13 rising edge on line 21
        set_cfg(21, 2'b01, 3'd1);
        irq_in[21] = 1'b1; @(posedge clk); @(posedge clk); #1;
        irq_in[21] = 1'b0; settle();
        rd(A_PEND, d); chk("R6 rise latched", d[21], 1);
        wr(A_CLR, 32'h0020_0000); settle();
        rd(A_PEND, d); chk("R13 cleared", d[21], 0);

        // R6 low level on line 22
        set_cfg(22, 2'b10, 3'd1); settle();
        rd(A_PEND, d); chk("R6 low level pend", d[22], 1);
        irq_in[22] = 1'b1; settle();
        rd(A_PEND, d); chk("R6 low level idle", d[22], 0);
        set_cfg(22, 2'b00, 3'd0); irq_in[22] = 1'b0; settle();

        // R10 protect mode
        irq_in[21] = 1'b1; @(posedge clk); @(posedge clk); #1;
        irq_in[21] = 1'b0; settle();
        wr(A_CTRL, 32'h2);
        rd(A_VEC, d); chk("R10 first read", d, vec_of(21));
        rd(A_VEC, d); chk("R10 second read", d, vec_of(21));
        rd(A_PEND, d); chk("R10 latch kept", d[21], 1);
        wr(A_VEC, 0); settle();
        rd(A_PEND, d); chk("R10 write accepts", d[21], 0);
        chk("R10 nirq quiet", 32'(nirq_n), 1);
        wr(A_EOI, 0);
        wr(A_CTRL, 32'h0);

        // R2 fast line
        irq_in[0] = 1'b1; settle();
        chk("R2 nfiq", 32'(nfiq_n), 0);
        chk("R2 no nirq", 32'(nirq_n), 1);
        irq_in[0] = 1'b0; settle();

        // R8 fast forcing
        wr(A_FORCE, 32'h40); irq_in[6] = 1'b1; settle();
        chk("R8 nfiq", 32'(nfiq_n), 0);
        chk("R8 no nirq", 32'(nirq_n), 1);
        irq_in[6] = 1'b0; wr(A_FORCE, 0); settle();

        // R9 global mask
        wr(A_CTRL, 32'h1); irq_in = 32'h9; settle();
        chk("R9 nirq masked", 32'(nirq_n), 1);
        chk("R9 nfiq masked", 32'(nfiq_n), 1);
        rd(A_PEND, d); chk("R9 pend seen", d & 32'h9, 32'h9);
        wr(A_CTRL, 32'h0); settle();
        chk("R9 nirq unmasked", 32'(nirq_n), 0);
        chk("R9 nfiq unmasked", 32'(nfiq_n), 0);
        irq_in = '0; settle();

        // R12 per-line enable
        wr(A_ENABLE, ~32'h20); irq_in[5] = 1'b1; settle();
        chk("R12 disabled quiet", 32'(nirq_n), 1);
        rd(A_PEND, d); chk("R12 pend shown", d[5], 1);
        wr(A_ENABLE, 32'hFFFF_FFFF); settle();
        chk("R12 enabled requests", 32'(nirq_n), 0);
        irq_in = '0; settle();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule